// File: doc/BRIEF.md
# Framed 16-bit Serial Register Loader

This block takes configuration words from a write-only, three-wire serial link and turns each complete 16-bit word into a parallel write in the system clock domain. The link has an active-low frame enable, a serial clock and a data line. While the frame enable is low, data is shifted in most significant bit first on each falling edge of the serial clock. Each group of 16 falling edges forms one word. A single low period may carry any number of back-to-back words.

The two top bits of every finished word are a routing tag. Tag `00` loads a control register whose fields are brought out as separate named outputs. The other three tags produce a one-cycle write strobe for one of two frequency registers or for a phase register, with the 14-bit payload on a shared data bus.

All three link inputs pass through two-flop synchronizers, and edges are detected after synchronization. The system clock must therefore run at least four times faster than the serial clock. The serial clock must be high at the moment the frame enable falls.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, every control field output is 0 and no write strobe is asserted.
- R2: A word is shifted in most significant bit first, one bit per falling serial clock edge. It is complete on the 16th falling edge after the frame enable falls.
- R3: While the frame enable is high, serial clock edges and data are ignored. No register changes, and the bit count restarts at zero.
- R4: If the frame enable rises before a word has 16 bits, the partial word is discarded. No strobe is produced and the control register does not change.
- R5: While the frame enable stays low, each further group of 16 falling edges forms a new word, which is decoded independently.
- R6: A word with bits 15:14 = `00` loads the control register. The fields are taken from these word bits:
  - bit 13 → `cfg_wide_load`
  - bit 12 → `cfg_upper_half`
  - bit 11 → `cfg_freq_sel`
  - bit 10 → `cfg_phase_sel`
  - bit 8 → `cfg_core_clear`
  - bit 7 → `cfg_clk_stop`
  - bit 6 → `cfg_dac_off`
  - bit 5 → `cfg_bit_out`
  - bit 3 → `cfg_half_msb`
  - bit 1 → `cfg_tri_wave`
- R7: Control word bits 9, 4, 2 and 0 are reserved. Their values have no effect on any output.
- R8: Bits 15:14 select a one-cycle write strobe, and in each case `wr_data` carries word bits 13:0:
  - `01` → `freq0_wr`
  - `10` → `freq1_wr`
  - `11` → `phase_wr`

  At most one strobe is high in any cycle.
- R9: Words with a nonzero tag leave every control field output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | Active-low frame enable from the link |
| sck | input | 1 | Serial clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data, most significant bit first |
| cfg_wide_load | output | 1 | Control field from word bit 13 |
| cfg_upper_half | output | 1 | Control field from word bit 12 |
| cfg_freq_sel | output | 1 | Control field from word bit 11 |
| cfg_phase_sel | output | 1 | Control field from word bit 10 |
| cfg_core_clear | output | 1 | Control field from word bit 8 |
| cfg_clk_stop | output | 1 | Control field from word bit 7 |
| cfg_dac_off | output | 1 | Control field from word bit 6 |
| cfg_bit_out | output | 1 | Control field from word bit 5 |
| cfg_half_msb | output | 1 | Control field from word bit 3 |
| cfg_tri_wave | output | 1 | Control field from word bit 1 |
| freq0_wr | output | 1 | One-cycle write strobe, tag 01 |
| freq1_wr | output | 1 | One-cycle write strobe, tag 10 |
| phase_wr | output | 1 | One-cycle write strobe, tag 11 |
| wr_data | output | 14 | Payload accompanying a write strobe |

## Verification
The assertions check these properties on every cycle:
- A finished word appears only while the synchronized frame enable is low.
- Strobes are mutually exclusive and last one cycle.
- Each strobe follows a finished word with a nonzero tag and carries that word's payload.
- The control register changes only after a control-tagged word, and then takes exactly the non-reserved bits of that word.

Only the bench scenarios can show that the bit order and the 16-edge word boundary are right on the wires. The same holds for discarding a partial frame, for ignoring clock activity while the frame is high, and for decoding several words within one low period.

// File: rtl/cfg_loader_pkg.sv
// Package: shared constants and types for the serial configuration loader.
// Assumes 16-bit words with a 2-bit routing tag in the top bits.
package cfg_loader_pkg;
    localparam int WORD_W = 16;
    localparam int TAG_W  = 2;
    localparam int PAY_W  = WORD_W - TAG_W;
    localparam int NUM_DEST = 3;

    // Mask of control fields that are stored; reserved bits 9, 4, 2, 0 are zero.
    localparam logic [PAY_W-1:0] CTRL_KEEP = 14'h3DEA;

    typedef enum logic [TAG_W-1:0] {
        TAG_CTRL  = 2'b00,
        TAG_FREQ0 = 2'b01,
        TAG_FREQ1 = 2'b10,
        TAG_PHASE = 2'b11
    } route_tag_e;

    // Returns the tag field of a complete word.
    function automatic route_tag_e word_tag(input logic [WORD_W-1:0] w);
        return route_tag_e'(w[WORD_W-1 -: TAG_W]);
    endfunction

    // Returns the payload field of a complete word.
    function automatic logic [PAY_W-1:0] word_payload(input logic [WORD_W-1:0] w);
        return w[PAY_W-1:0];
    endfunction
endpackage

// File: rtl/cfg_sync_chain.sv
// Module: multi-bit synchronizer chain, one flop chain per bit.
// Assumes each bit is an independent slow level; no bus coherency is implied.
module cfg_sync_chain #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the asynchronous inputs into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= async_in;
            end
        end else begin : g_next
            // Pass the value one stage further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_serial_deframer.sv
// Module: detects falling serial clock edges inside a frame, shifts bits in
// MSB first and emits each complete word with a one-cycle valid pulse.
// Assumes synchronized inputs and a serial clock at most clk/4.
module cfg_serial_deframer #(
    parameter int WORD_W = cfg_loader_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_q
);
    localparam int              CNT_W    = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    logic              sck_prev;
    logic              sck_fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] next_word;

    assign sck_fall  = sck_prev & ~sck_s;
    assign next_word = {shreg[WORD_W-2:0], sdi_s};

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b1;
        else        sck_prev <= sck_s;
    end

    // Shift bits and count them; a high frame enable restarts the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (frame_s) begin
            bit_cnt <= '0;
        end else if (sck_fall) begin
            shreg   <= next_word;
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        end
    end

    // Publish a finished word with a one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_vld <= 1'b0;
            word_q   <= '0;
        end else begin
            word_vld <= !frame_s && sck_fall && (bit_cnt == LAST_BIT);
            if (!frame_s && sck_fall && (bit_cnt == LAST_BIT))
                word_q <= next_word;
        end
    end
endmodule

// File: rtl/cfg_word_router.sv
// Module: decodes the tag of each finished word. Control words load the
// masked control register; other tags raise one write strobe with payload.
// Assumes word_vld is a single-cycle pulse.
module cfg_word_router
    import cfg_loader_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_vld,
    input  logic [W-1:0]        word_q,
    output logic [PAY_W-1:0]    ctrl_q,
    output logic [PAY_W-1:0]    wr_data,
    output logic [NUM_DEST-1:0] dest_wr
);
    route_tag_e tag;
    assign tag = word_tag(word_q);

    // Load the control register from control-tagged words, reserved bits cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ctrl_q <= '0;
        else if (word_vld && tag == TAG_CTRL)   ctrl_q <= word_payload(word_q) & CTRL_KEEP;
    end

    // Raise the strobe matching a nonzero tag for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_wr <= '0;
        end else begin
            for (int i = 0; i < NUM_DEST; i++)
                dest_wr[i] <= word_vld && (tag == route_tag_e'(i + 1));
        end
    end

    // Hold the payload of the most recent data word.
    always_ff @(posedge clk) begin
        if (!rst_n)                           wr_data <= '0;
        else if (word_vld && tag != TAG_CTRL) wr_data <= word_payload(word_q);
    end
endmodule

// File: rtl/serial_cfg_loader.sv
// Module: top of the framed 16-bit serial register loader.
// Synchronizes the link, deframes words and routes them to control fields or
// write strobes. Assumes clk is at least four times the serial clock rate and
// that the serial clock is high when frame_n falls.
module serial_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             sck,
    input  logic             sdi,
    output logic             cfg_wide_load,
    output logic             cfg_upper_half,
    output logic             cfg_freq_sel,
    output logic             cfg_phase_sel,
    output logic             cfg_core_clear,
    output logic             cfg_clk_stop,
    output logic             cfg_dac_off,
    output logic             cfg_bit_out,
    output logic             cfg_half_msb,
    output logic             cfg_tri_wave,
    output logic             freq0_wr,
    output logic             freq1_wr,
    output logic             phase_wr,
    output logic [PAY_W-1:0] wr_data
);
    logic [2:0]          link_s;
    logic                frame_s;
    logic                sck_s;
    logic                sdi_s;
    logic                word_vld;
    logic [WORD_W-1:0]   word_q;
    logic [PAY_W-1:0]    ctrl_q;
    logic [NUM_DEST-1:0] dest_wr;

    cfg_sync_chain #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b110)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({frame_n, sck, sdi}),
        .sync_out (link_s)
    );

    assign {frame_s, sck_s, sdi_s} = link_s;

    cfg_serial_deframer #(
        .WORD_W (WORD_W)
    ) u_deframer (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_s  (frame_s),
        .sck_s    (sck_s),
        .sdi_s    (sdi_s),
        .word_vld (word_vld),
        .word_q   (word_q)
    );

    cfg_word_router #(
        .W (WORD_W)
    ) u_router (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_vld (word_vld),
        .word_q   (word_q),
        .ctrl_q   (ctrl_q),
        .wr_data  (wr_data),
        .dest_wr  (dest_wr)
    );

    assign cfg_wide_load  = ctrl_q[13];
    assign cfg_upper_half = ctrl_q[12];
    assign cfg_freq_sel   = ctrl_q[11];
    assign cfg_phase_sel  = ctrl_q[10];
    assign cfg_core_clear = ctrl_q[8];
    assign cfg_clk_stop   = ctrl_q[7];
    assign cfg_dac_off    = ctrl_q[6];
    assign cfg_bit_out    = ctrl_q[5];
    assign cfg_half_msb   = ctrl_q[3];
    assign cfg_tri_wave   = ctrl_q[1];

    assign freq0_wr = dest_wr[0];
    assign freq1_wr = dest_wr[1];
    assign phase_wr = dest_wr[2];
endmodule

// File: rtl/serial_cfg_loader_chk.sv
// Module: property checker for the serial configuration loader, bound to
// the top so it sees the finished-word pulse and the control register.
module serial_cfg_loader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_s,
    input logic        word_vld,
    input logic [15:0] word_q,
    input logic [13:0] ctrl_q,
    input logic [13:0] wr_data,
    input logic [2:0]  strb
);
    localparam logic [13:0] KEEP = 14'h3DEA;

    // R3
    word_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> !frame_s);

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb));

    // R8
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb != 3'b000) |=> (strb == 3'b000));

    // R8
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb != 3'b000) |-> ($past(word_vld) && $past(word_q[15:14]) != 2'b00
                              && wr_data == $past(word_q[13:0])));

    // R6
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(word_vld) && $past(word_q[15:14]) == 2'b00)
            |-> (ctrl_q == ($past(word_q[13:0]) & KEEP)));

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(word_vld) || $past(word_q[15:14]) != 2'b00) |-> $stable(ctrl_q));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_s  (frame_s),
    .word_vld (word_vld),
    .word_q   (word_q),
    .ctrl_q   (ctrl_q),
    .wr_data  (wr_data),
    .strb     ({phase_wr, freq1_wr, freq0_wr})
);

// File: tb/serial_cfg_loader_bench.sv
module serial_cfg_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        sck = 1'b1;
    logic        sdi = 1'b0;
    logic        f_wide, f_upper, f_fsel, f_psel, f_clear, f_stop, f_dac, f_bit, f_half, f_tri;
    logic        freq0_wr, freq1_wr, phase_wr;
    logic [13:0] wr_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Strobe log filled by the monitor, expected log filled by the model.
    int          log_n = 0;
    logic [1:0]  log_kind [256];
    logic [13:0] log_data [256];
    int          exp_n = 0;
    logic [1:0]  exp_kind [256];
    logic [13:0] exp_data [256];
    int          seen_n = 0;
    logic [13:0] exp_ctrl = '0;

    always #2 clk = ~clk;

    serial_cfg_loader u_serial_cfg_loader (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sck(sck), .sdi(sdi),
        .cfg_wide_load(f_wide), .cfg_upper_half(f_upper), .cfg_freq_sel(f_fsel),
        .cfg_phase_sel(f_psel), .cfg_core_clear(f_clear), .cfg_clk_stop(f_stop),
        .cfg_dac_off(f_dac), .cfg_bit_out(f_bit), .cfg_half_msb(f_half),
        .cfg_tri_wave(f_tri), .freq0_wr(freq0_wr), .freq1_wr(freq1_wr),
        .phase_wr(phase_wr), .wr_data(wr_data)
    );

    // Record every strobe; kind 1 freq0, 2 freq1, 3 phase.
    always @(negedge clk) begin
        if (rst_n && (freq0_wr || freq1_wr || phase_wr) && log_n < 256) begin
            log_kind[log_n] = freq0_wr ? 2'd1 : (freq1_wr ? 2'd2 : 2'd3);
            log_data[log_n] = wr_data;
            log_n++;
        end
    end

    function automatic logic [13:0] ctrl_view();
        return {f_wide, f_upper, f_fsel, f_psel, 1'b0, f_clear, f_stop, f_dac,
                f_bit, 1'b0, f_half, 1'b0, f_tri, 1'b0};
    endfunction

    // Reference model of one complete word (R6, R7, R8).
    function automatic void model_word(input logic [15:0] w);
        if (w[15:14] == 2'b00) begin
            exp_ctrl = w[13:0] & 14'h3DEA;
        end else if (exp_n < 256) begin
            exp_kind[exp_n] = w[15:14];
            exp_data[exp_n] = w[13:0];
            exp_n++;
        end
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        #16 sck = 1'b0;
        #16 sck = 1'b1;
    endtask

    task automatic frame_open();
        @(negedge clk);
        sck = 1'b1;
        frame_n = 1'b0;
        #16;
    endtask

    task automatic frame_close();
        #16 frame_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
    endtask

    // Compare all new strobe entries and the control fields with the model.
    task automatic compare(input string req);
        chk(log_n == exp_n, {req, " strobe count"}, log_n, exp_n);
        for (int i = seen_n; i < log_n && i < exp_n; i++) begin
            chk(log_kind[i] == exp_kind[i], {req, " strobe kind"}, log_kind[i], exp_kind[i]);
            chk(log_data[i] == exp_data[i], {req, " wr_data"}, log_data[i], exp_data[i]);
        end
        seen_n = log_n;
        chk(ctrl_view() == exp_ctrl, {req, " control fields"}, ctrl_view(), exp_ctrl);
    endtask

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk(ctrl_view() == 14'h0, "R1 control fields after reset", ctrl_view(), 0);
        chk(log_n == 0, "R1 no strobe after reset", log_n, 0);

        // R6 R7 all ones control word, reserved bits dropped
        frame_open(); send_word(16'h3FFF); frame_close();
        model_word(16'h3FFF);
        compare("R6 R7 all-ones control");

        // R6 individual field positions
        frame_open(); send_word(16'h2108); frame_close();
        model_word(16'h2108);
        chk(f_wide == 1 && f_clear == 1 && f_half == 1 && f_fsel == 0,
            "R6 field positions", ctrl_view(), 14'h2108);
        compare("R6 field word");

        // R2 bit order with an asymmetric word
        frame_open(); send_word(16'h0002); frame_close();
        model_word(16'h0002);
        chk(f_tri == 1 && f_wide == 0, "R2 MSB first", ctrl_view(), 14'h0002);

        // R8 R9 frequency-0 write leaves control fields untouched
        frame_open(); send_word(16'h4ABC); frame_close();
        model_word(16'h4ABC);
        compare("R8 R9 freq0 write");

        // R5 three words in one low period
        frame_open();
        send_word(16'h8123); send_word(16'hC3FE); send_word(16'h0042);
        frame_close();
        model_word(16'h8123); model_word(16'hC3FE); model_word(16'h0042);
        compare("R5 back-to-back words");

        // R4 partial word discarded, next frame starts fresh
        frame_open();
        for (int i = 0; i < 12; i++) send_bit(1'b1);
        frame_close();
        compare("R4 partial word");
        frame_open(); send_word(16'h5555); frame_close();
        model_word(16'h5555);
        compare("R4 word after partial");

        // R3 clock activity with frame high is ignored
        for (int i = 0; i < 21; i++) begin
            sdi = 1'($urandom);
            #16 sck = 1'b0;
            #16 sck = 1'b1;
        end
        repeat (12) @(negedge clk);
        compare("R3 clock with frame high");
        frame_open(); send_word(16'h0008); frame_close();
        model_word(16'h0008);
        compare("R3 count restart");

        // R2 R5 R6 R7 R8 random frames, some ending in a partial word
        for (int f = 0; f < 30; f++) begin
            int nw = 1 + ($urandom % 3);
            frame_open();
            for (int k = 0; k < nw; k++) begin
                logic [15:0] w = 16'($urandom);
                send_word(w);
                model_word(w);
            end
            if ($urandom % 5 == 0) begin
                int extra = 1 + ($urandom % 15);
                for (int b = 0; b < extra; b++) send_bit(1'($urandom));
            end
            frame_close();
            compare("R8 random frame");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule